// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM device from reset to a usable state. While the supply settles it keeps the clock enable and the data mask high and puts only no-operation commands on the command bus for a long, parameterized pause. It then closes every bank with a single precharge-all command. After that it programs the mode register with the value presented on `mode_val_i` and issues a burst of auto-refresh commands. A parameter sets whether the refreshes come before or after the mode register write. Every gap is counted in clock cycles.

When the sequence ends, the block raises `init_done_o` and hands the command bus over to normal traffic. From then on a refresh-rate timer emits a one-cycle request each interval. A small counter holds the requests that the consumer has not yet acknowledged, so a late acknowledgement does not lose a refresh.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: Commands are encoded on `cmd_o` as {cs_n, ras_n, cas_n, we_n}: NOP 0111, precharge 0010, auto-refresh 0001, mode register set 0000. From reset until the pause ends, `cmd_o` is NOP, `addr_o` is 0, `cke_o` and `dqm_o` are 1 and `init_done_o` is 0.
- R2: The pause lasts exactly PAUSE_CYC cycles. Counting the first rising edge after reset release as edge 1, the first non-NOP command appears after edge PAUSE_CYC. The default of 20000 cycles at 100 MHz equals 200 µs.
- R3: The first command is precharge-all, which is `cmd_o` = 0010 with `addr_o` bit 10 set and every other address bit 0.
- R4: Each command is on the bus for one cycle only. Every other cycle carries NOP with `addr_o` = 0. The next command follows precharge-all no sooner than TRP_CYC cycles later.
- R5: Exactly NUM_REF auto-refresh commands are issued during initialization. Consecutive refreshes are exactly TRC_CYC cycles apart.
- R6: The mode register set carries `mode_val_i` zero-extended on `addr_o` and is issued only after the precharge. With REF_FIRST=1 it comes TRC_CYC cycles after the last refresh. With REF_FIRST=0 it comes TRP_CYC cycles after the precharge, and the first refresh follows TMRD_CYC cycles after it.
- R7: `init_done_o` rises TMRD_CYC cycles after the mode register set (REF_FIRST=1) or TRC_CYC cycles after the last refresh (REF_FIRST=0) and then stays high. `dqm_o` falls in the same cycle and `cke_o` stays high.
- R8: `ref_req_o` is a one-cycle pulse. It is never high before `init_done_o`. The first pulse comes REF_INT_CYC-1 cycles after `init_done_o` rises, and later pulses follow every REF_INT_CYC cycles.
- R9: `ref_pend_o` goes up by one the cycle after each pulse and down by one the cycle after a cycle with `ref_ack_i` high. It saturates at 2^PEND_W-1, and an acknowledge while the count is 0 leaves it at 0.
- R10: Once `init_done_o` is high, `cmd_o` stays NOP and `addr_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_val_i | input | MODE_W | Value written to the mode register |
| ref_ack_i | input | 1 | Consumer took one pending refresh |
| cmd_o | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| addr_o | output | ADDR_W | Address bus (precharge-all flag, mode value) |
| cke_o | output | 1 | Clock enable |
| dqm_o | output | 1 | Data mask, high until initialization ends |
| init_done_o | output | 1 | Device ready for normal use |
| ref_req_o | output | 1 | One-cycle refresh interval pulse |
| ref_pend_o | output | PEND_W | Refreshes requested and not yet acknowledged |

## Verification
A phase counter or state that goes wrong shows up at the ports as a command in the wrong cycle: a shifted edge, a doubled or missing refresh, or a mode write placed ahead of the precharge. Comparing the command and address buses against an independently computed schedule on every cycle of the sequence catches such an error in the cycle where it first occurs. A wrong refresh timer or pending counter shows one interval later as a pulse at the wrong cycle, or as a count that fails to move (or moves when it should not) one cycle after a request or an acknowledge.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PRE,
    ST_REF,
    ST_MRS,
    ST_DONE
  } init_st_e;
endpackage

// File: rtl/sdram_cycle_timer.sv
module sdram_cycle_timer #(
  parameter int              W       = 8,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= RST_VAL;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int PAUSE_CYC = 20000,
  parameter int TRP_CYC   = 2,
  parameter int TRC_CYC   = 7,
  parameter int TMRD_CYC  = 2,
  parameter int NUM_REF   = 8,
  parameter bit REF_FIRST = 1'b1,
  parameter int ADDR_W    = 13,
  parameter int MODE_W    = 13,
  parameter int AP_BIT    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_val_i,
  output logic [3:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dqm_o,
  output logic              done_o
);
  localparam int MAX_A   = (TRP_CYC > TRC_CYC) ? TRP_CYC : TRC_CYC;
  localparam int MAX_B   = (MAX_A > TMRD_CYC) ? MAX_A : TMRD_CYC;
  localparam int MAX_DUR = (MAX_B > PAUSE_CYC) ? MAX_B : PAUSE_CYC;
  localparam int CNT_W   = $clog2(MAX_DUR + 1);
  localparam int REF_W   = $clog2(NUM_REF + 1);
  localparam int MIN_A   = (TRP_CYC < TRC_CYC) ? TRP_CYC : TRC_CYC;
  localparam int MIN_GAP = (MIN_A < TMRD_CYC) ? MIN_A : TMRD_CYC;

  init_st_e          state_q, state_d;
  logic              first_q;
  logic              pre_seen_q;
  logic [REF_W-1:0]  ref_cnt_q;
  logic [CNT_W-1:0]  dur_d;
  logic              tmr_zero;
  logic              advance;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PAUSE: state_d = ST_PRE;
      ST_PRE:   state_d = REF_FIRST ? ST_REF : ST_MRS;
      ST_REF:   if (ref_cnt_q == REF_W'(NUM_REF - 1))
                  state_d = REF_FIRST ? ST_MRS : ST_DONE;
                else
                  state_d = ST_REF;
      ST_MRS:   state_d = REF_FIRST ? ST_DONE : ST_REF;
      default:  state_d = ST_DONE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_PRE:  dur_d = CNT_W'(TRP_CYC - 1);
      ST_REF:  dur_d = CNT_W'(TRC_CYC - 1);
      ST_MRS:  dur_d = CNT_W'(TMRD_CYC - 1);
      default: dur_d = '0;
    endcase
  end

  assign advance = tmr_zero && (state_q != ST_DONE);

  sdram_cycle_timer #(
    .W       (CNT_W),
    .RST_VAL (CNT_W'(PAUSE_CYC - 1))
  ) u_phase_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (advance),
    .load_val_i (dur_d),
    .zero_o     (tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_PAUSE;
      first_q    <= 1'b0;
      pre_seen_q <= 1'b0;
      ref_cnt_q  <= '0;
    end else begin
      first_q <= advance;
      if (advance) state_q <= state_d;
      if (state_q == ST_PRE) pre_seen_q <= 1'b1;
      if (advance && state_q == ST_REF) ref_cnt_q <= ref_cnt_q + 1'b1;
    end
  end

  // command only in the first cycle of a phase; the rest of the phase is the gap
  always_comb begin
    cmd_o  = CMD_NOP;
    addr_o = '0;
    if (first_q) begin
      unique case (state_q)
        ST_PRE: begin
          cmd_o          = CMD_PRE;
          addr_o[AP_BIT] = 1'b1;
        end
        ST_REF: cmd_o = CMD_REF;
        ST_MRS: begin
          cmd_o  = CMD_MRS;
          addr_o = ADDR_W'(mode_val_i);
        end
        default: ;
      endcase
    end
  end

  assign done_o = (state_q == ST_DONE);
  assign dqm_o  = !done_o;

  assert_pre_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_PAUSE && state_q == ST_PRE) |-> (cmd_o == CMD_PRE && addr_o[AP_BIT]));

  assert_cmd_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MIN_GAP > 1 && cmd_o != CMD_NOP) |=> (cmd_o == CMD_NOP));

  assert_ref_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_cnt_q <= REF_W'(NUM_REF));

  assert_mrs_after_pre_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_MRS) |-> pre_seen_q);

  assert_done_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  assert_quiet_after_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(done_o) |-> (cmd_o == CMD_NOP && addr_o == '0));
endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int INT_CYC = 1562,
  parameter int PEND_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [PEND_W-1:0] pend_o
);
  localparam int                CNT_W    = $clog2(INT_CYC + 1);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic              tmr_zero;
  logic [PEND_W-1:0] pend_q;
  logic              inc, dec;

  sdram_cycle_timer #(
    .W       (CNT_W),
    .RST_VAL (CNT_W'(INT_CYC - 1))
  ) u_int_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (!en_i || tmr_zero),
    .load_val_i (CNT_W'(INT_CYC - 1)),
    .zero_o     (tmr_zero)
  );

  assign req_o = en_i && tmr_zero;
  assign inc   = req_o && (pend_q != PEND_MAX);
  assign dec   = ack_i && (pend_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pend_q <= '0;
    else if (inc && !dec) pend_q <= pend_q + 1'b1;
    else if (dec && !inc) pend_q <= pend_q - 1'b1;
  end

  assign pend_o = pend_q;

  assert_req_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> en_i);

  assert_req_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (INT_CYC > 1 && req_o) |=> !req_o);

  assert_pend_inc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i && pend_q != PEND_MAX) |=> (pend_q == $past(pend_q) + 1'b1));

  assert_pend_floor_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !req_o && pend_q == '0) |=> (pend_q == '0));
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq #(
  parameter int PAUSE_CYC   = 20000,
  parameter int TRP_CYC     = 2,
  parameter int TRC_CYC     = 7,
  parameter int TMRD_CYC    = 2,
  parameter int NUM_REF     = 8,
  parameter bit REF_FIRST   = 1'b1,
  parameter int REF_INT_CYC = 1562,
  parameter int PEND_W      = 4,
  parameter int ADDR_W      = 13,
  parameter int MODE_W      = 13,
  parameter int AP_BIT      = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_val_i,
  input  logic              ref_ack_i,
  output logic [3:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cke_o,
  output logic              dqm_o,
  output logic              init_done_o,
  output logic              ref_req_o,
  output logic [PEND_W-1:0] ref_pend_o
);
  logic done;

  sdram_init_fsm #(
    .PAUSE_CYC (PAUSE_CYC),
    .TRP_CYC   (TRP_CYC),
    .TRC_CYC   (TRC_CYC),
    .TMRD_CYC  (TMRD_CYC),
    .NUM_REF   (NUM_REF),
    .REF_FIRST (REF_FIRST),
    .ADDR_W    (ADDR_W),
    .MODE_W    (MODE_W),
    .AP_BIT    (AP_BIT)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_val_i (mode_val_i),
    .cmd_o      (cmd_o),
    .addr_o     (addr_o),
    .dqm_o      (dqm_o),
    .done_o     (done)
  );

  sdram_ref_timer #(
    .INT_CYC (REF_INT_CYC),
    .PEND_W  (PEND_W)
  ) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (done),
    .ack_i  (ref_ack_i),
    .req_o  (ref_req_o),
    .pend_o (ref_pend_o)
  );

  // clock enable stays high from reset onward
  assign cke_o       = 1'b1;
  assign init_done_o = done;
endmodule

// File: tb/sim_sdram_pwrup_seq.sv
module sim_sdram_pwrup_seq;
  localparam int P    = 20000;
  localparam int TRP  = 2;
  localparam int TRC  = 7;
  localparam int TMRD = 2;
  localparam int N    = 8;
  localparam int INTV = 1562;
  localparam int PW   = 4;

  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;
  localparam logic [12:0] MODE0 = 13'h0032, MODE1 = 13'h0023, AP = 13'h0400;

  localparam int R0   = P + TRP;            // first refresh, refresh-first order
  localparam int MRS0 = P + TRP + N * TRC;  // mode write, refresh-first order
  localparam int D    = MRS0 + TMRD;        // init done, both orders
  localparam int T1   = D + INTV - 1;       // first refresh request

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ack0 = 1'b0, ack1 = 1'b0;
  logic [3:0]  cmd0, cmd1;
  logic [12:0] adr0, adr1;
  logic cke0, cke1, dqm0, dqm1, dn0, dn1, rq0, rq1;
  logic [PW-1:0] pd0, pd1;
  int cyc = 0, wd = 0, n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  sdram_pwrup_seq #(.PAUSE_CYC(P), .TRP_CYC(TRP), .TRC_CYC(TRC), .TMRD_CYC(TMRD),
    .NUM_REF(N), .REF_FIRST(1'b1), .REF_INT_CYC(INTV), .PEND_W(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_val_i(MODE0), .ref_ack_i(ack0),
    .cmd_o(cmd0), .addr_o(adr0), .cke_o(cke0), .dqm_o(dqm0),
    .init_done_o(dn0), .ref_req_o(rq0), .ref_pend_o(pd0));

  sdram_pwrup_seq #(.PAUSE_CYC(P), .TRP_CYC(TRP), .TRC_CYC(TRC), .TMRD_CYC(TMRD),
    .NUM_REF(N), .REF_FIRST(1'b0), .REF_INT_CYC(INTV), .PEND_W(PW)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_val_i(MODE1), .ref_ack_i(ack1),
    .cmd_o(cmd1), .addr_o(adr1), .cke_o(cke1), .dqm_o(dqm1),
    .init_done_o(dn1), .ref_req_o(rq1), .ref_pend_o(pd1));

  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s @cyc %0d: actual %0h expected %0h", req, what, cyc, act, exp);
    end
  endtask

  task automatic wait_to(int k);
    while (cyc < k) @(negedge clk);
  endtask

  // expected {cmd, addr} from the schedule in the requirements
  function automatic logic [16:0] exp_bus(int k, bit rf, logic [12:0] mode);
    int r_base, m_at;
    r_base = rf ? P + TRP : P + TRP + TMRD;
    m_at   = rf ? P + TRP + N * TRC : P + TRP;
    if (k == P) return {PRE, AP};
    if (k == m_at) return {MRS, mode};
    if (k >= r_base && k < r_base + N * TRC && ((k - r_base) % TRC) == 0) return {REF, 13'h0};
    return {NOP, 13'h0};
  endfunction

  function automatic string tag_of(int k, bit rf);
    int r_base, m_at;
    r_base = rf ? P + TRP : P + TRP + TMRD;
    m_at   = rf ? P + TRP + N * TRC : P + TRP;
    if (k < P) return "R1";
    if (k == P) return "R3";
    if (k == m_at) return "R6";
    if (k >= r_base && k < r_base + N * TRC) return "R5";
    if (k >= D) return "R10";
    return "R4";
  endfunction

  // per-cycle sweep of the whole sequence on both orders
  always @(negedge clk) begin
    if (rst_ni && cyc <= D + 3) begin
      chk(tag_of(cyc, 1'b1), "u0 bus", {15'h0, cmd0, adr0}, {15'h0, exp_bus(cyc, 1'b1, MODE0)});
      chk(tag_of(cyc, 1'b0), "u1 bus", {15'h0, cmd1, adr1}, {15'h0, exp_bus(cyc, 1'b0, MODE1)});
      chk("R7", "cke", {30'h0, cke0, cke1}, 32'h3);
      chk((cyc < P) ? "R1" : "R7", "dqm", {30'h0, dqm0, dqm1}, (cyc < D) ? 32'h3 : 32'h0);
      chk("R8", "req before done", {30'h0, rq0, rq1}, 32'h0);
    end
  end

  // vector table for the refresh-first instance
  localparam int NV = 11;
  localparam int V_CYC [NV] = '{P-1, P, P+1, R0, R0+TRC-1, R0+TRC, R0+(N-1)*TRC, MRS0, D-1, D, D+1};
  localparam logic [3:0]  V_CMD [NV] = '{NOP, PRE, NOP, REF, NOP, REF, REF, MRS, NOP, NOP, NOP};
  localparam logic [12:0] V_ADR [NV] = '{13'h0, AP, 13'h0, 13'h0, 13'h0, 13'h0, 13'h0, MODE0, 13'h0, 13'h0, 13'h0};
  localparam logic        V_DN  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  // requirement per row: R2 R2 R4 R5 R5 R5 R5 R6 R7 R7 R10
  localparam int V_REQ [NV] = '{2, 2, 4, 5, 5, 5, 5, 6, 7, 7, 10};

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset cmd", {28'h0, cmd0}, {28'h0, NOP});
    chk("R1", "reset addr", {19'h0, adr0}, 32'h0);
    chk("R1", "reset cke/dqm/done", {29'h0, cke0, dqm0, dn0}, 32'h6);
    chk("R9", "reset req/pend", {27'h0, rq0, pd0}, 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      wait_to(V_CYC[i]);
      chk($sformatf("R%0d", V_REQ[i]), "u0 cmd", {28'h0, cmd0}, {28'h0, V_CMD[i]});
      chk($sformatf("R%0d", V_REQ[i]), "u0 addr", {19'h0, adr0}, {19'h0, V_ADR[i]});
      chk($sformatf("R%0d", V_REQ[i]), "u0 done", {31'h0, dn0}, {31'h0, V_DN[i]});
    end

    // mode-first order: MRS right after tRP, refreshes tMRD later, done at same cycle
    chk("R7", "u1 done at D+1", {31'h0, dn1}, 32'h1);

    // ack at zero pending is ignored
    wait_to(D + 5);
    ack1 = 1'b1;
    @(negedge clk);
    ack1 = 1'b0;
    chk("R9", "u1 ack at zero", {28'h0, pd1}, 32'h0);

    wait_to(T1 - 1);
    chk("R8", "req early", {30'h0, rq0, rq1}, 32'h0);
    wait_to(T1);
    chk("R8", "first req", {30'h0, rq0, rq1}, 32'h3);
    wait_to(T1 + 1);
    chk("R8", "req single", {30'h0, rq0, rq1}, 32'h0);
    chk("R9", "u0 pend 1", {28'h0, pd0}, 32'h1);
    chk("R9", "u1 pend 1", {28'h0, pd1}, 32'h1);
    ack1 = 1'b1;
    @(negedge clk);
    ack1 = 1'b0;
    chk("R9", "u1 pend after ack", {28'h0, pd1}, 32'h0);
    chk("R9", "u0 pend held", {28'h0, pd0}, 32'h1);

    wait_to(T1 + INTV - 1);
    chk("R8", "second req early", {31'h0, rq0}, 32'h0);
    wait_to(T1 + INTV);
    chk("R8", "second req", {31'h0, rq0}, 32'h1);
    wait_to(T1 + INTV + 1);
    chk("R9", "u0 pend 2", {28'h0, pd0}, 32'h2);
    chk("R10", "quiet bus", {15'h0, cmd0, adr0}, {15'h0, NOP, 13'h0});

    // 17 requests with no ack: count stops at 15
    wait_to(T1 + 16 * INTV + 1);
    chk("R9", "u0 pend saturated", {28'h0, pd0}, 32'h0000000F);
    chk("R10", "quiet bus late", {15'h0, cmd1, adr1}, {15'h0, NOP, 13'h0});

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == 120000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", wd);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule